// File: doc/BRIEF.md
# Multi-mode ADC conversion sequencer

This block is the digital control sequencer of a four-input analog-to-digital converter with a parallel bus. It runs on the system clock. It watches the bus strobes (chip select, read, write) and a dedicated conversion-start pin. From these it decides when the sample-and-hold tracks, when the converter core runs and when results are presented. The analog front end and the converter core are not part of it. A stub outside the block delivers the two channel results on `resultA` and `resultB`.

Four conversion modes are selected by a 2-bit configuration field:

| Field value | Mode |
|---|---|
| 2'b00 | single-channel interrupt |
| 2'b01 | dual-channel interrupt |
| 2'b10 | single-channel continuous |
| 2'b11 | dual-channel continuous |

A clock-source bit selects an internal or an external conversion clock, and the two sources give different conversion lengths. The field and the bit are loaded by a bus write.

- In the interrupt modes, a finished conversion pulls the active-low interrupt low, and a read releases it.
- In the continuous modes, the read strobe itself paces the conversions.

All strobes pass through a synchroniser of two flip-flops before their edges are detected. Every pin event therefore takes effect on the third rising clock edge after the pin changes.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, `intN` is 1, `dataValid` is 0, `convertPhase` is 0 and `samplePhase` is 1.
- R2: Trigger sources depend on the mode. In single interrupt (00), a read or a start-pin falling edge starts a conversion. In dual interrupt (01), only the start pin does, and a read starts nothing. In the continuous modes (10, 11), only reads start conversions, and the start pin is ignored.
- R3: Falling edges on `startN` are accepted whether `csN` is high or low. Reads and writes act only while `csN` is low.
- R4: `convertPhase` stays high for a fixed number of clocks. A single conversion lasts 6 clocks with the internal source (`cfgExtClk`=0) or 5 with the external source (`cfgExtClk`=1). A dual conversion lasts 12 or 10 clocks.
- R5: `samplePhase` is high in every cycle that is not a conversion cycle. After a trigger edge, it stays high for D clocks before `convertPhase` rises. D is 2 for a read in a single mode, 7 for a read in dual continuous mode, and 1 for the start pin. Counting the first rising edge after the pin change as edge 1, `convertPhase` is first high after edge 3+D.
- R6: When a conversion ends in an interrupt mode, `intN` goes low on the same edge that `convertPhase` falls. The next accepted read sets it high again; in dual interrupt this is the first read. In the continuous modes, `intN` stays high.
- R7: When a conversion ends, `dataOut` shows the first-channel result and `dataValid` goes high. In single modes, a read drops `dataValid`. In dual modes, the first read switches `dataOut` to the second-channel result, and the second read drops `dataValid`.
- R8: In single continuous mode, every read taken while idle starts a conversion. In dual continuous mode, a read starts one only when no result is pending or when it is the second read of a pending pair.
- R9: A write rising edge with `csN` low loads `cfgMode` and `cfgExtClk` and aborts any conversion. It also clears `dataValid` and sets `intN` high.
- R10: Trigger edges that arrive while a conversion is pending or running are ignored and do not lengthen it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low; configuration loads on its rising edge |
| startN | input | 1 | Conversion-start pin, falling edge triggers |
| cfgMode | input | 2 | Mode field loaded by a write |
| cfgExtClk | input | 1 | Clock-source select loaded by a write (1 = external) |
| resultA | input | DATA_W | First-channel result from the converter stub |
| resultB | input | DATA_W | Second-channel result from the converter stub |
| samplePhase | output | 1 | Sample-and-hold tracking phase |
| convertPhase | output | 1 | Converter core running |
| intN | output | 1 | Active-low conversion-done interrupt |
| dataValid | output | 1 | A result is presented on dataOut |
| dataOut | output | DATA_W | Result presented to the parallel bus |

## Verification
The bench builds the block with its default parameters: 10-bit results, conversion lengths of 6 and 5 clocks, read-to-conversion delays of 2 and 7 clocks, a start delay of 1 clock, and two synchroniser stages. With these values, every mode, both clock sources, the 12- and 10-clock dual conversions and a configuration write landing mid-conversion all fit inside a few hundred cycles. The trigger-to-conversion delays and conversion widths are then measured exactly against the 3+D edge count.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE_IRQ  = 2'b00,
    MODE_DUAL_IRQ    = 2'b01,
    MODE_SINGLE_CONT = 2'b10,
    MODE_DUAL_CONT   = 2'b11
  } convMode_t;

  // strobes from the control FSM to the result datapath
  typedef struct packed {
    logic abort;    // configuration write: drop everything
    logic capture;  // conversion finished: latch both channel results
    logic consume;  // accepted bus read
    logic dual;     // current mode converts two channels
    logic irqMode;  // current mode reports through the interrupt
  } seqStrobe_t;

endpackage

// File: rtl/conv_seq_sync.sv
module conv_seq_sync #(
  parameter int NUM_PINS = 4,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] level,
  output logic [NUM_PINS-1:0] fallEv,
  output logic [NUM_PINS-1:0] riseEv
);

  for (genvar b = 0; b < NUM_PINS; b++) begin : g_pin
    logic [STAGES-1:0] chain;
    logic              prevLevel;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain     <= '1;
        prevLevel <= 1'b1;
      end else begin
        chain     <= {chain[STAGES-2:0], pinIn[b]};
        prevLevel <= chain[STAGES-1];
      end
    end

    assign level[b]  = chain[STAGES-1];
    assign fallEv[b] = prevLevel & ~chain[STAGES-1];
    assign riseEv[b] = ~prevLevel & chain[STAGES-1];
  end

endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int CONV_INT        = 6,
  parameter int CONV_EXT        = 5,
  parameter int RD_DELAY_SINGLE = 2,
  parameter int RD_DELAY_DUAL   = 7,
  parameter int START_DELAY     = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdEv,
  input  logic       wrEv,
  input  logic       stEv,
  input  logic [1:0] cfgModeIn,
  input  logic       cfgExtIn,
  input  logic       resValid,
  input  logic       resHalf,
  output seqStrobe_t strobe,
  output logic       samplePhase,
  output logic       convertPhase
);

  localparam int LONGEST_CONV = (CONV_INT > CONV_EXT) ? 2 * CONV_INT : 2 * CONV_EXT;
  localparam int LONGEST_WAIT = (RD_DELAY_DUAL > RD_DELAY_SINGLE) ? RD_DELAY_DUAL : RD_DELAY_SINGLE;
  localparam int MAX_COUNT    = (LONGEST_CONV > LONGEST_WAIT) ? LONGEST_CONV : LONGEST_WAIT;
  localparam int CNT_W        = $clog2(MAX_COUNT + 1);

  localparam logic [CNT_W-1:0] LAST_S_INT = CNT_W'(CONV_INT - 1);
  localparam logic [CNT_W-1:0] LAST_S_EXT = CNT_W'(CONV_EXT - 1);
  localparam logic [CNT_W-1:0] LAST_D_INT = CNT_W'(2 * CONV_INT - 1);
  localparam logic [CNT_W-1:0] LAST_D_EXT = CNT_W'(2 * CONV_EXT - 1);
  localparam logic [CNT_W-1:0] WAIT_RD_S  = CNT_W'(RD_DELAY_SINGLE - 1);
  localparam logic [CNT_W-1:0] WAIT_RD_D  = CNT_W'(RD_DELAY_DUAL - 1);
  localparam logic [CNT_W-1:0] WAIT_START = CNT_W'(START_DELAY - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CONV} seqState_t;

  seqState_t        state;
  convMode_t        mode;
  logic             extClk;
  logic [CNT_W-1:0] cnt;
  logic             isDual;
  logic             isIrq;
  logic [CNT_W-1:0] convLast;
  logic [CNT_W-1:0] waitLast;
  logic             rdTrig;
  logic             stTrig;
  logic             startGo;

  assign isDual = mode[0];
  assign isIrq  = ~mode[1];

  always_comb begin
    if (isDual) convLast = extClk ? LAST_D_EXT : LAST_D_INT;
    else        convLast = extClk ? LAST_S_EXT : LAST_S_INT;
  end

  // trigger qualification per mode
  always_comb begin
    rdTrig = 1'b0;
    stTrig = 1'b0;
    unique case (mode)
      MODE_SINGLE_IRQ:  begin rdTrig = rdEv; stTrig = stEv; end
      MODE_DUAL_IRQ:    stTrig = stEv;
      MODE_SINGLE_CONT: rdTrig = rdEv;
      MODE_DUAL_CONT:   rdTrig = rdEv & (~resValid | resHalf);
      default:          ;
    endcase
  end

  assign startGo  = (state == ST_IDLE) & (rdTrig | stTrig) & ~wrEv;
  assign waitLast = rdTrig ? (isDual ? WAIT_RD_D : WAIT_RD_S) : WAIT_START;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      mode   <= MODE_SINGLE_IRQ;
      extClk <= 1'b0;
      cnt    <= '0;
    end else if (wrEv) begin
      mode   <= convMode_t'(cfgModeIn);
      extClk <= cfgExtIn;
      state  <= ST_IDLE;
      cnt    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (startGo) begin
          state <= ST_WAIT;
          cnt   <= waitLast;
        end
        ST_WAIT: if (cnt == '0) begin
          state <= ST_CONV;
          cnt   <= convLast;
        end else begin
          cnt <= cnt - 1'b1;
        end
        ST_CONV: if (cnt == '0) begin
          state <= ST_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign convertPhase = (state == ST_CONV);
  assign samplePhase  = ~convertPhase;

  assign strobe.abort   = wrEv;
  assign strobe.capture = (state == ST_CONV) & (cnt == '0) & ~wrEv;
  assign strobe.consume = rdEv;
  assign strobe.dual    = isDual;
  assign strobe.irqMode = isIrq;

  // independent run-length counter for the width check
  logic [CNT_W-1:0] runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 runLen <= '0;
    else if (state == ST_CONV) runLen <= runLen + 1'b1;
    else                       runLen <= '0;
  end

  AST_SAMPLE_BEFORE_CONV: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convertPhase) |-> $past(state) == ST_WAIT); // R5
  AST_CONV_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> runLen == convLast); // R4
  AST_DUAL_IRQ_READ_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && mode == MODE_DUAL_IRQ && rdEv && !stEv && !wrEv) |=> state == ST_IDLE); // R2
  AST_WRITE_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    wrEv |=> state == ST_IDLE); // R9
  AST_BUSY_IGNORES_TRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && cnt != '0 && !wrEv) |=> state == ST_CONV); // R10

endmodule

// File: rtl/conv_seq_data.sv
module conv_seq_data
  import conv_seq_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] resA,
  input  logic [DATA_W-1:0] resB,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              resHalf,
  output logic              intN
);

  logic [DATA_W-1:0] heldB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut   <= '0;
      heldB     <= '0;
      dataValid <= 1'b0;
      resHalf   <= 1'b0;
      intN      <= 1'b1;
    end else if (strobe.abort) begin
      dataValid <= 1'b0;
      resHalf   <= 1'b0;
      intN      <= 1'b1;
    end else if (strobe.capture) begin
      dataOut   <= resA;
      heldB     <= resB;
      dataValid <= 1'b1;
      resHalf   <= 1'b0;
      intN      <= ~strobe.irqMode;
    end else if (strobe.consume && dataValid) begin
      intN <= 1'b1;
      if (strobe.dual && !resHalf) begin
        dataOut <= heldB;
        resHalf <= 1'b1;
      end else begin
        dataValid <= 1'b0;
        resHalf   <= 1'b0;
      end
    end
  end

  AST_CONT_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.irqMode |-> intN); // R6
  AST_CAPTURE_PRESENTS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.abort) |=> dataValid && !resHalf); // R7
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.abort |=> !dataValid && intN); // R9
  AST_SECOND_READ_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.consume && dataValid && strobe.dual && resHalf && !strobe.capture && !strobe.abort)
    |=> !dataValid); // R7

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int DATA_W          = 10,
  parameter int SYNC_STAGES     = 2,
  parameter int CONV_INT        = 6,
  parameter int CONV_EXT        = 5,
  parameter int RD_DELAY_SINGLE = 2,
  parameter int RD_DELAY_DUAL   = 7,
  parameter int START_DELAY     = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              startN,
  input  logic [1:0]        cfgMode,
  input  logic              cfgExtClk,
  input  logic [DATA_W-1:0] resultA,
  input  logic [DATA_W-1:0] resultB,
  output logic              samplePhase,
  output logic              convertPhase,
  output logic              intN,
  output logic              dataValid,
  output logic [DATA_W-1:0] dataOut
);

  localparam int PIN_CS    = 0;
  localparam int PIN_RD    = 1;
  localparam int PIN_WR    = 2;
  localparam int PIN_START = 3;
  localparam int NUM_PINS  = 4;

  logic [NUM_PINS-1:0] pinLevel;
  logic [NUM_PINS-1:0] pinFall;
  logic [NUM_PINS-1:0] pinRise;
  logic                rdEv;
  logic                wrEv;
  logic                stEv;
  logic                resValid;
  logic                resHalf;
  seqStrobe_t          strobe;

  conv_seq_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  ({startN, wrN, rdN, csN}),
    .level  (pinLevel),
    .fallEv (pinFall),
    .riseEv (pinRise)
  );

  assign rdEv = pinFall[PIN_RD] & ~pinLevel[PIN_CS];
  assign wrEv = pinRise[PIN_WR] & ~pinLevel[PIN_CS];
  assign stEv = pinFall[PIN_START];

  conv_seq_ctrl #(
    .CONV_INT        (CONV_INT),
    .CONV_EXT        (CONV_EXT),
    .RD_DELAY_SINGLE (RD_DELAY_SINGLE),
    .RD_DELAY_DUAL   (RD_DELAY_DUAL),
    .START_DELAY     (START_DELAY)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .rdEv         (rdEv),
    .wrEv         (wrEv),
    .stEv         (stEv),
    .cfgModeIn    (cfgMode),
    .cfgExtIn     (cfgExtClk),
    .resValid     (resValid),
    .resHalf      (resHalf),
    .strobe       (strobe),
    .samplePhase  (samplePhase),
    .convertPhase (convertPhase)
  );

  conv_seq_data #(.DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .resA      (resultA),
    .resB      (resultB),
    .dataOut   (dataOut),
    .dataValid (resValid),
    .resHalf   (resHalf),
    .intN      (intN)
  );

  assign dataValid = resValid;

endmodule

// File: tb/sim_conv_sequencer.sv
module sim_conv_sequencer;

  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         csN = 1'b1;
  logic         rdN = 1'b1;
  logic         wrN = 1'b1;
  logic         startN = 1'b1;
  logic [1:0]   cfgMode = 2'b00;
  logic         cfgExtClk = 1'b0;
  logic [W-1:0] resultA = 10'h155;
  logic [W-1:0] resultB = 10'h2AA;
  logic         samplePhase;
  logic         convertPhase;
  logic         intN;
  logic         dataValid;
  logic [W-1:0] dataOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int expLenQ[$];
  int runLen = 0;

  logic         snapValid;
  logic         snapInt;
  logic [W-1:0] snapData;

  always #5 clk = ~clk;

  conv_sequencer u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN), .startN(startN),
    .cfgMode(cfgMode), .cfgExtClk(cfgExtClk), .resultA(resultA), .resultB(resultB),
    .samplePhase(samplePhase), .convertPhase(convertPhase), .intN(intN),
    .dataValid(dataValid), .dataOut(dataOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: measures every conversion pulse against the expected queue (R4)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (convertPhase) begin
        runLen++;
      end else if (runLen > 0) begin
        if (expLenQ.size() == 0) begin
          check(0, "R4 unexpected conversion", runLen, 0);
        end else begin
          int e;
          e = expLenQ.pop_front();
          if (e >= 0) check(runLen == e, "R4 conversion width", runLen, e);
        end
        runLen = 0;
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfgWrite(input logic [1:0] m, input logic ext);
    @(negedge clk);
    cfgMode = m; cfgExtClk = ext; csN = 1'b0; wrN = 1'b0;
    tick(); tick();
    wrN = 1'b1;
    tick(); tick(); tick();
    csN = 1'b1;
  endtask

  // read pulse: snapshot at edge 3, then count edges until conversion starts
  task automatic doRead(input bit csLow, output int delay);
    @(negedge clk);
    csN = csLow ? 1'b0 : 1'b1;
    rdN = 1'b0;
    tick(); tick(); tick();
    snapValid = dataValid; snapInt = intN; snapData = dataOut;
    rdN = 1'b1;
    delay = 0;
    for (int i = 4; i <= 16; i++) begin
      tick();
      if (convertPhase) begin delay = i; break; end
    end
    csN = 1'b1;
  endtask

  task automatic doStart(output int delay);
    @(negedge clk);
    startN = 1'b0;
    delay = 0;
    for (int i = 1; i <= 16; i++) begin
      tick();
      if (i == 3) startN = 1'b1;
      if (convertPhase) begin delay = i; break; end
    end
    startN = 1'b1;
  endtask

  task automatic waitIdle();
    while (convertPhase) tick();
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int d;
    int seen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    // R1 reset state
    check(intN == 1'b1, "R1 intN", intN, 1);
    check(dataValid == 1'b0, "R1 dataValid", dataValid, 0);
    check(convertPhase == 1'b0, "R1 convertPhase", convertPhase, 0);
    check(samplePhase == 1'b1, "R1 samplePhase", samplePhase, 1);

    // single interrupt, internal clock; start pin with csN high (R3)
    cfgWrite(2'b00, 1'b0);
    expLenQ.push_back(6);
    doStart(d);
    check(d == 4, "R3 R5 start delay csN high", d, 4);
    waitIdle();
    check(intN == 1'b0, "R6 irq after single", intN, 0);
    check(dataValid == 1'b1, "R7 valid after single", dataValid, 1);
    check(dataOut == 10'h155, "R7 dataOut first", dataOut, 10'h155);

    // read clears irq, drops valid, and retriggers in single interrupt
    resultA = 10'h0F0;
    expLenQ.push_back(6);
    doRead(1'b1, d);
    check(snapInt == 1'b1, "R6 read clears irq", snapInt, 1);
    check(snapValid == 1'b0, "R7 single read drops valid", snapValid, 0);
    check(d == 5, "R2 R5 read delay single", d, 5);
    waitIdle();
    check(dataOut == 10'h0F0, "R7 new result", dataOut, 10'h0F0);

    // read with csN high is ignored (R3)
    doRead(1'b0, d);
    check(d == 0, "R3 read without cs no trigger", d, 0);
    check(snapValid == 1'b1 && snapInt == 1'b0, "R3 read without cs no consume", snapValid, 1);

    // dual interrupt, external clock
    cfgWrite(2'b01, 1'b1);
    check(dataValid == 1'b0 && intN == 1'b1, "R9 write clears", dataValid, 0);
    doRead(1'b1, d);
    check(d == 0, "R2 dual irq read ignored", d, 0);
    resultA = 10'h155;
    expLenQ.push_back(10);
    doStart(d);
    check(d == 4, "R5 dual start delay", d, 4);
    waitIdle();
    check(intN == 1'b0, "R6 dual irq", intN, 0);
    check(dataOut == 10'h155, "R7 dual first", dataOut, 10'h155);
    doRead(1'b1, d);
    check(snapInt == 1'b1, "R6 first read clears irq", snapInt, 1);
    check(snapData == 10'h2AA && snapValid == 1'b1, "R7 second channel", snapData, 10'h2AA);
    doRead(1'b1, d);
    check(snapValid == 1'b0, "R7 second read drops valid", snapValid, 0);

    // start edge during conversion ignored (R10)
    expLenQ.push_back(10);
    doStart(d);
    @(negedge clk);
    startN = 1'b0;
    tick(); tick(); tick();
    startN = 1'b1;
    waitIdle();
    seen = 0;
    for (int i = 0; i < 15; i++) begin
      tick();
      if (convertPhase) seen++;
    end
    check(seen == 0, "R10 busy start ignored", seen, 0);

    // abort mid-conversion by configuration write (R9), into dual continuous internal
    expLenQ.push_back(-1);
    doStart(d);
    cfgWrite(2'b11, 1'b0);
    check(convertPhase == 1'b0, "R9 abort stops conversion", convertPhase, 0);
    check(dataValid == 1'b0 && intN == 1'b1, "R9 abort clears results", dataValid, 0);

    // dual continuous
    expLenQ.push_back(12);
    doRead(1'b1, d);
    check(d == 10, "R5 dual continuous delay", d, 10);
    waitIdle();
    check(intN == 1'b1, "R6 continuous no irq", intN, 1);
    check(dataValid == 1'b1 && dataOut == 10'h155, "R7 dual cont first", dataOut, 10'h155);
    doRead(1'b1, d);
    check(d == 0, "R8 first read of pair no trigger", d, 0);
    check(snapData == 10'h2AA, "R7 dual cont second", snapData, 10'h2AA);
    expLenQ.push_back(12);
    doRead(1'b1, d);
    check(d == 10, "R8 last read triggers", d, 10);
    check(snapValid == 1'b0, "R7 last read drops valid", snapValid, 0);
    waitIdle();

    // single continuous, external clock
    cfgWrite(2'b10, 1'b1);
    doStart(d);
    check(d == 0, "R2 start ignored in continuous", d, 0);
    expLenQ.push_back(5);
    doRead(1'b1, d);
    check(d == 5, "R8 single cont read triggers", d, 5);
    waitIdle();
    check(dataValid == 1'b1 && intN == 1'b1, "R6 single cont valid no irq", dataValid, 1);
    expLenQ.push_back(5);
    doRead(1'b1, d);
    check(d == 5, "R8 every read triggers", d, 5);
    check(snapValid == 1'b0, "R7 single cont read drops valid", snapValid, 0);
    waitIdle();
    tick();

    check(expLenQ.size() == 0, "R4 all conversions seen", expLenQ.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule